// File: doc/BRIEF.md
# Masked Indirect Access Controller

This block is the random-access read and write path of a small associative memory. Each entry holds a data word and a validity flag. Commands arrive one per clock on a strobe-qualified command interface. A 12-bit address/control bus carries one of two things. When the active-low address-valid strobe is low, the bus holds an entry address for a direct access. When the strobe is high, the bus holds an opcode for an indirect access. An indirect access goes through an internal address register, which is left alone, incremented or decremented after the access has used it.

Writes can be bit-masked by one of seven mask registers. Selector 0 is hard-wired to mean "no mask". Every write also stores the entry's validity flag. Every read returns the stored flag together with the data, registered one clock later. A side load port writes the address register, the mask registers and the selector used by direct writes.

Top module: `mcam_access`

## Requirements
- R1: While `cmd_valid` is high and `av_n` is low, the low `ADDR_W` bits of `ac` address an entry directly. `wr_n` low writes `din` into that entry, and `wr_n` high reads it.
- R2: While `cmd_valid` and `av_n` are high, the opcode field is {`ac[8:6]`,`ac[2:0]`}. The value 000000 accesses the entry at the address register and leaves the register unchanged. The value 100110 accesses it and then adds one. The value 100111 with `wr_n` low writes it and then subtracts one. Bits `ac[11:9]` are ignored.
- R3: For indirect writes, `ac[5:3]` picks a mask register. Value 0 writes all bits. Any other value updates only the bit positions where the chosen mask holds 0 and keeps the others.
- R4: A direct write is masked by the mask register named by the configuration selector, with the same rule as R3.
- R5: Each write stores the validity flag, valid when `vb_in_n` is 0 and empty when it is 1. Each read drives the stored flag on `vb_out_n`, with 0 meaning valid.
- R6: Read data and flag appear on `dout`/`vb_out_n` one clock after the read command. They hold their value in cycles without a read.
- R7: The address register changes only after the access has used its old value. It wraps modulo 2^`ADDR_W` in both directions, and direct accesses leave it unchanged.
- R8: With `ld_en` high, `ld_sel` 0 loads the address register from `ld_data`. Values 1 to 7 load that mask register, and value 8 loads the configuration selector from `ld_data[2:0]`. An address load in the same cycle as an increment or decrement wins.
- R9: Any other indirect opcode, including 100111 with `wr_n` high, changes neither the array, the address register nor the outputs.
- R10: After reset, all validity flags are empty, the address register is 0, all masks and the selector are 0, `dout` is 0 and `vb_out_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| wr_n | input | 1 | Low = write, high = read |
| av_n | input | 1 | Low = `ac` is a direct address, high = opcode |
| ac | input | CMD_W | Address/control bus |
| din | input | DATA_W | Write data |
| vb_in_n | input | 1 | Validity to store on a write, low = valid |
| ld_en | input | 1 | Register load strobe |
| ld_sel | input | LDSEL_W | Load target select |
| ld_data | input | DATA_W | Load value |
| dout | output | DATA_W | Registered read data |
| vb_out_n | output | 1 | Registered read validity, low = valid |

## Verification
The bench builds the block with `ADDR_W` = 4, which gives a 16-entry array. At that size the wrap of the address register in both directions takes only a few commands. Data width and bus width keep their defaults of 32 and 12, so upper-half and lower-half mask patterns and junk in the ignored opcode bits are all exercised at full width.

// File: rtl/mcam_pkg.sv
// Shared types and constants for the masked indirect access controller.
package mcam_pkg;
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    localparam logic [5:0] OPF_PLAIN = 6'b000000;
    localparam logic [5:0] OPF_UP    = 6'b100110;
    localparam logic [5:0] OPF_DOWN  = 6'b100111;
endpackage

// File: rtl/mcam_decode.sv
// Command decoder. It turns the strobes and the address/control bus into an
// access (read or write), the entry address, a mask selector and an address step.
// Assumes CMD_W >= 9 and ADDR_W <= CMD_W.
module mcam_decode
    import mcam_pkg::*;
#(
    parameter int CMD_W  = 12,
    parameter int ADDR_W = 6,
    parameter int MSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic              wr_n,
    input  logic              av_n,
    input  logic [CMD_W-1:0]  ac,
    input  logic [ADDR_W-1:0] areg,
    input  logic [MSEL_W-1:0] cfg_msel,
    output logic              rd_en,
    output logic              wr_en,
    output logic [ADDR_W-1:0] acc_addr,
    output logic [MSEL_W-1:0] msel,
    output step_e             step
);
    logic [5:0] opf;
    assign opf = {ac[8:6], ac[2:0]};

    // Decode direct or indirect command into access controls.
    always_comb begin
        rd_en    = 1'b0;
        wr_en    = 1'b0;
        acc_addr = areg;
        msel     = '0;
        step     = STEP_HOLD;
        if (cmd_valid) begin
            if (!av_n) begin
                acc_addr = ac[ADDR_W-1:0];
                rd_en    = wr_n;
                wr_en    = !wr_n;
                msel     = cfg_msel;
            end else begin
                case (opf)
                    OPF_PLAIN: begin
                        rd_en = wr_n;
                        wr_en = !wr_n;
                        msel  = ac[5:3];
                    end
                    OPF_UP: begin
                        rd_en = wr_n;
                        wr_en = !wr_n;
                        msel  = ac[5:3];
                        step  = STEP_UP;
                    end
                    OPF_DOWN: begin
                        if (!wr_n) begin
                            wr_en = 1'b1;
                            msel  = ac[5:3];
                            step  = STEP_DOWN;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R2
    step_needs_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step != STEP_HOLD) |-> (rd_en || wr_en));
    // R1
    direct_no_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !av_n) |-> (step == STEP_HOLD));
endmodule

// File: rtl/mcam_regs.sv
// Register file: the address register, mask registers 1..NMASK-1 (mask 0 is
// fixed at all-zero, which means "update all bits") and the direct-write
// mask selector. The selected write mask comes out combinationally.
module mcam_regs
    import mcam_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int ADDR_W  = 6,
    parameter int MSEL_W  = 3,
    localparam int NMASK   = 1 << MSEL_W,
    localparam int LDSEL_W = $clog2(NMASK + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ld_en,
    input  logic [LDSEL_W-1:0] ld_sel,
    input  logic [DATA_W-1:0]  ld_data,
    input  step_e              step,
    input  logic [MSEL_W-1:0]  msel,
    output logic [ADDR_W-1:0]  areg,
    output logic [MSEL_W-1:0]  cfg_msel,
    output logic [DATA_W-1:0]  wmask
);
    logic [DATA_W-1:0] mask_q [NMASK];
    logic              ld_areg;
    assign ld_areg = ld_en && (ld_sel == LDSEL_W'(0));

    // Address register: a load wins over the post-access step.
    always_ff @(posedge clk) begin
        if (!rst_n)        areg <= '0;
        else if (ld_areg)  areg <= ld_data[ADDR_W-1:0];
        else if (step == STEP_UP)   areg <= areg + 1'b1;
        else if (step == STEP_DOWN) areg <= areg - 1'b1;
    end

    // Direct-write mask selector.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_msel <= '0;
        else if (ld_en && ld_sel == LDSEL_W'(NMASK)) cfg_msel <= ld_data[MSEL_W-1:0];
    end

    for (genvar g = 0; g < NMASK; g++) begin : g_mask
        if (g == 0) begin : g_fixed
            assign mask_q[g] = '0;
        end else begin : g_reg
            // Loadable mask register g.
            always_ff @(posedge clk) begin
                if (!rst_n) mask_q[g] <= '0;
                else if (ld_en && ld_sel == LDSEL_W'(g)) mask_q[g] <= ld_data;
            end
        end
    end

    assign wmask = mask_q[msel];

    // R7
    areg_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_areg && step == STEP_UP) |=> (areg == ADDR_W'($past(areg) + 1'b1)));
    // R7
    areg_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_areg && step == STEP_DOWN) |=> (areg == ADDR_W'($past(areg) - 1'b1)));
    // R7
    areg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_areg && step == STEP_HOLD) |=> $stable(areg));
    // R8
    areg_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_areg |=> (areg == $past(ld_data[ADDR_W-1:0])));
endmodule

// File: rtl/mcam_array.sv
// Data array with a validity flag per entry. A write merges new data under the
// mask (a 0 mask bit takes new data) and stores the flag. A read registers the
// data and flag, and the outputs hold between reads. Data words are not reset.
module mcam_array #(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              vld_in,
    input  logic [DATA_W-1:0] wmask,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_vld
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  vld;

    // Masked data write.
    always_ff @(posedge clk) begin
        if (rst_n && wr_en) mem[addr] <= (mem[addr] & wmask) | (din & ~wmask);
    end

    // Validity flags: cleared at reset, set or cleared on each write.
    always_ff @(posedge clk) begin
        if (!rst_n)     vld <= '0;
        else if (wr_en) vld[addr] <= vld_in;
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            rd_vld  <= 1'b0;
        end else if (rd_en) begin
            rd_data <= mem[addr];
            rd_vld  <= vld[addr];
        end
    end

    // R6
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> ($stable(rd_data) && $stable(rd_vld)));
    // R5
    wr_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (vld[$past(addr)] == $past(vld_in)));
    // R3
    full_mask_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wmask == '1) |=> (mem[$past(addr)] === $past(mem[addr])));
    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (vld == '0 && !rd_vld && rd_data == '0));
endmodule

// File: rtl/mcam_access.sv
// Top of the masked indirect access controller. It connects the decoder, the
// register file and the data array. Assumes one command per clock, and that
// read results are taken from dout/vb_out_n one clock after the command.
module mcam_access
    import mcam_pkg::*;
#(
    parameter int CMD_W  = 12,
    parameter int DATA_W = 32,
    parameter int ADDR_W = 6,
    parameter int MSEL_W = 3,
    localparam int LDSEL_W = $clog2((1 << MSEL_W) + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cmd_valid,
    input  logic               wr_n,
    input  logic               av_n,
    input  logic [CMD_W-1:0]   ac,
    input  logic [DATA_W-1:0]  din,
    input  logic               vb_in_n,
    input  logic               ld_en,
    input  logic [LDSEL_W-1:0] ld_sel,
    input  logic [DATA_W-1:0]  ld_data,
    output logic [DATA_W-1:0]  dout,
    output logic               vb_out_n
);
    logic              rd_en, wr_en, rd_vld;
    logic [ADDR_W-1:0] acc_addr, areg;
    logic [MSEL_W-1:0] msel, cfg_msel;
    logic [DATA_W-1:0] wmask;
    step_e             step;

    mcam_decode #(.CMD_W(CMD_W), .ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_n(wr_n), .av_n(av_n),
        .ac(ac), .areg(areg), .cfg_msel(cfg_msel), .rd_en(rd_en), .wr_en(wr_en),
        .acc_addr(acc_addr), .msel(msel), .step(step)
    );

    mcam_regs #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .MSEL_W(MSEL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_sel(ld_sel), .ld_data(ld_data),
        .step(step), .msel(msel), .areg(areg), .cfg_msel(cfg_msel), .wmask(wmask)
    );

    mcam_array #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_arr (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .wr_en(wr_en), .addr(acc_addr),
        .din(din), .vld_in(!vb_in_n), .wmask(wmask), .rd_data(dout), .rd_vld(rd_vld)
    );

    assign vb_out_n = !rd_vld;
endmodule

// File: tb/mcam_access_test.sv
// Bench: a behavioural reference model is stepped with every clock and
// compared with the outputs after each edge.
module mcam_access_test;
    localparam int CW = 12, DW = 32, AW = 4, NE = 16;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cmd_valid = 0, wr_n = 1, av_n = 1, vb_in_n = 1, ld_en = 0;
    logic [CW-1:0] ac = '0;
    logic [DW-1:0] din = '0, ld_data = '0;
    logic [3:0] ld_sel = '0;
    logic [DW-1:0] dout;
    logic vb_out_n;

    mcam_access #(.CMD_W(CW), .DATA_W(DW), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wr_n(wr_n), .av_n(av_n),
        .ac(ac), .din(din), .vb_in_n(vb_in_n), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_data(ld_data), .dout(dout), .vb_out_n(vb_out_n)
    );

    always #10 clk = ~clk;

    int tests = 0, fails = 0;
    bit done = 0;
    logic [DW-1:0] m_mem [NE];
    bit            m_vld [NE];
    logic [DW-1:0] m_mask [8];
    int            m_cfg = 0, m_areg = 0;
    logic [DW-1:0] e_dout = '0;
    bit            e_vbn = 1;

    task automatic check(input string tag);
        tests++;
        if ((!$isunknown(e_dout) && dout !== e_dout) || vb_out_n !== e_vbn) begin
            fails++;
            $display("FAIL %s: dout=%h vb_out_n=%b expected dout=%h vb_out_n=%b",
                     tag, dout, vb_out_n, e_dout, e_vbn);
        end
    endtask

    // One clock: drive inputs, advance the model, compare after the edge.
    task automatic cyc(input bit cv, input bit wn, input bit avn, input logic [CW-1:0] a,
                       input logic [DW-1:0] d, input bit vbn, input bit le,
                       input logic [3:0] ls, input logic [DW-1:0] ldv, input string tag);
        int adr, ms, stp;
        bit rd, wr;
        logic [5:0] op;
        logic [DW-1:0] m;
        @(negedge clk);
        cmd_valid = cv; wr_n = wn; av_n = avn; ac = a; din = d; vb_in_n = vbn;
        ld_en = le; ld_sel = ls; ld_data = ldv;
        rd = 0; wr = 0; stp = 0; adr = m_areg; ms = 0;
        if (cv) begin
            if (!avn) begin
                adr = int'(a[AW-1:0]); rd = wn; wr = !wn; ms = m_cfg;
            end else begin
                op = {a[8:6], a[2:0]};
                ms = int'(a[5:3]);
                if (op == 6'b000000) begin rd = wn; wr = !wn; end
                else if (op == 6'b100110) begin rd = wn; wr = !wn; stp = 1; end
                else if (op == 6'b100111 && !wn) begin wr = 1; stp = -1; end
            end
        end
        if (rd) begin e_dout = m_mem[adr]; e_vbn = !m_vld[adr]; end
        if (wr) begin
            m = (ms == 0) ? '0 : m_mask[ms];
            m_mem[adr] = (m_mem[adr] & m) | (d & ~m);
            m_vld[adr] = !vbn;
        end
        if (le && ls == 0) m_areg = int'(ldv[AW-1:0]);
        else m_areg = (m_areg + stp + NE) % NE;
        if (le && ls >= 1 && ls <= 7) m_mask[ls] = ldv;
        if (le && ls == 8) m_cfg = int'(ldv[2:0]);
        @(posedge clk);
        #2;
        check(tag);
    endtask

    task automatic dwr(input int a, input logic [DW-1:0] d, input bit vbn, input string tag);
        cyc(1, 0, 0, CW'(a), d, vbn, 0, 0, '0, tag);
    endtask
    task automatic drd(input int a, input string tag);
        cyc(1, 1, 0, CW'(a), '0, 1, 0, 0, '0, tag);
    endtask
    task automatic iop(input bit wn, input logic [5:0] op, input logic [2:0] nnn,
                       input logic [DW-1:0] d, input bit vbn, input string tag);
        cyc(1, wn, 1, {3'b101, op[5:3], nnn, op[2:0]}, d, vbn, 0, 0, '0, tag);
    endtask
    task automatic ldr(input logic [3:0] s, input logic [DW-1:0] v, input string tag);
        cyc(0, 1, 1, '0, '0, 1, 1, s, v, tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NE; i++) begin m_mem[i] = 'x; m_vld[i] = 0; end
        for (int i = 0; i < 8; i++) m_mask[i] = '0;
        repeat (4) @(posedge clk);
        @(negedge clk); rst_n = 1;
        #1;
        check("R10 reset outputs");
        drd(5, "R10 flag empty after reset");
        // R1 direct write and read back
        dwr(5, 32'hA5A5_1234, 0, "R1 direct write");
        drd(5, "R1 direct read");
        // R5 empty flag stored and returned
        dwr(6, 32'h1234_5678, 1, "R5 write empty");
        drd(6, "R5 read empty flag");
        cyc(0, 1, 1, '0, '0, 1, 0, 0, '0, "R6 hold without read");
        // R8 loads, R4 direct masked write
        ldr(1, 32'hFFFF_0000, "R8 load mask1");
        ldr(2, 32'h0F0F_0F0F, "R8 load mask2");
        ldr(8, 32'd1, "R8 load selector");
        dwr(5, 32'hCAFE_BABE, 0, "R4 direct masked write");
        drd(5, "R4 upper half kept");
        ldr(8, 32'd0, "R8 selector back to 0");
        // R7 increment with wrap 14,15,0
        ldr(0, 32'd14, "R8 load address");
        iop(0, 6'b100110, 3'd0, 32'h1111_0001, 0, "R7 write inc 14");
        iop(0, 6'b100110, 3'd0, 32'h2222_0002, 0, "R7 write inc 15");
        iop(0, 6'b100110, 3'd0, 32'h3333_0003, 1, "R7 write inc wrap 0");
        ldr(0, 32'd14, "R8 reload address");
        iop(1, 6'b100110, 3'd0, '0, 1, "R2 read inc 14");
        iop(1, 6'b100110, 3'd0, '0, 1, "R2 read inc 15");
        iop(1, 6'b100110, 3'd0, '0, 1, "R7 read inc wrapped 0");
        // R7 decrement with wrap 0 -> 15
        ldr(0, 32'd0, "R8 address 0");
        iop(0, 6'b100111, 3'd0, 32'h4444_0004, 0, "R7 write dec at 0");
        iop(0, 6'b100111, 3'd0, 32'h5555_0005, 0, "R7 write dec at 15");
        drd(0, "R7 entry 0 after dec");
        drd(15, "R7 entry 15 after dec");
        iop(1, 6'b000000, 3'd0, '0, 1, "R7 direct kept address 14");
        // R3 masked indirect writes
        iop(0, 6'b000000, 3'd2, 32'hFFFF_FFFF, 0, "R3 mask2 write");
        iop(1, 6'b000000, 3'd0, '0, 1, "R3 mask2 result");
        iop(0, 6'b100110, 3'd1, 32'h0000_0000, 0, "R3 mask1 write inc");
        drd(14, "R3 mask1 result");
        iop(1, 6'b000000, 3'd0, '0, 1, "R2 plain read at 15");
        // R9 unlisted opcodes
        iop(0, 6'b010101, 3'd0, 32'hDEAD_DEAD, 0, "R9 bad write opcode");
        iop(1, 6'b100111, 3'd0, '0, 1, "R9 read with dec opcode");
        iop(1, 6'b000000, 3'd0, '0, 1, "R9 address and entry unchanged");
        // R8 load wins over increment in the same cycle
        dwr(3, 32'h0303_0303, 0, "R1 direct write 3");
        cyc(1, 1, 1, {3'b000, 3'b100, 3'b000, 3'b110}, '0, 1, 1, 0, 32'd3, "R8 load with inc");
        iop(1, 6'b000000, 3'd0, '0, 1, "R8 load won");
        done = 1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule